// File: doc/BRIEF.md
# Pin Interrupt Controller

This block watches a small group of input pins and turns each one into its own interrupt request line. Each pin is sampled through a synchroniser. Depending on a per-pin mode bit, it then raises its request either on a latched edge or while the pin sits at a chosen level. Software configures and services the block through a plain register port: an address, a write strobe, write data, and combinational read data.

Two enable registers are present, one for rising edges and one for falling edges. Each can be written in three ways: a full load, a set-only view and a clear-only view. With the set-only and clear-only views, independent pieces of software can each flip their own pin's enable in one write. No read-modify-write is needed, so there is no race with an interrupt handler touching a neighbouring bit. In level mode, the rising-enable bit gates the pin and the falling-enable bit picks the active level. Writing 1 to a pin's status bit flips that level, so a handler can catch both transitions in turn. In edge mode, the same status write clears the latched edge.

Top module: `pin_irq_ctrl`

## Requirements
- R1: Offset 0x00 holds one mode bit per pin (0 = edge, 1 = level). It is loaded by a write and reads back. After reset, every register at offsets 0x00 to 0x1C reads 0, and `irq_o` is 0.
- R2: A write to offset 0x04 loads the whole rising-enable register from `wdata_i`, and a read of 0x04 returns it.
- R3: At offset 0x08, each 1 bit sets the matching rising-enable bit. At offset 0x0C, each 1 bit clears it. Bits written as 0 at either offset leave the register unchanged. Reads of 0x08 and 0x0C return the rising-enable register.
- R4: The falling-enable register behaves the same way: full load at 0x10, set-only at 0x14, clear-only at 0x18, and all three read back the register.
- R5: In edge mode, a rising pin edge is latched when its rising enable is 1, and a falling edge is latched when its falling enable is 1. The latched bit drives `irq_o` and bit i of the 0x1C read. It becomes visible after the third rising clock edge following the pin change.
- R6: An edge that occurs while its type is disabled is never latched, and enabling that type later raises no request.
- R7: In edge mode, writing 1 to a bit of offset 0x1C clears that pin's latched edge. Writing 0 leaves the bit unchanged.
- R8: If a clearing write to 0x1C and a newly detected enabled edge fall in the same cycle, the latched bit stays set.
- R9: In level mode, `irq_o[i]` and status bit i equal rising-enable bit i AND (synchronised pin == falling-enable bit i). So the request follows the pin after the second rising clock edge following a pin change, and it is always 0 while the rising enable is 0.
- R10: In level mode, writing 1 to bit i of offset 0x1C inverts falling-enable bit i, which reads back at 0x10. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pins_i | input | NPINS | Asynchronous pin inputs |
| addr_i | input | AW | Byte address of the register port |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| irq_o | output | NPINS | Per-pin interrupt request |

## Verification
The assertions assume that `wr_i` is a single-cycle strobe, that `addr_i` and `wdata_i` are stable around the clock edge, and that reset is asserted before the first clock edge. The bench drives every input on the falling clock edge and holds reset from time zero, so these conditions always hold. Random writes range over all eight mapped offsets. Pin values change only on falling edges, so each change lands cleanly in the first synchroniser stage and the cycle-counted latency in the requirements is exact.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned OFF_MODE = 32'h00;
  localparam int unsigned OFF_REN  = 32'h04;
  localparam int unsigned OFF_RSET = 32'h08;
  localparam int unsigned OFF_RCLR = 32'h0C;
  localparam int unsigned OFF_FEN  = 32'h10;
  localparam int unsigned OFF_FSET = 32'h14;
  localparam int unsigned OFF_FCLR = 32'h18;
  localparam int unsigned OFF_STAT = 32'h1C;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [STAGES-1:0][NPINS-1:0] stg_q, stg_d;
  logic [NPINS-1:0]             prev_q;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], pins_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs #(
  parameter int NPINS = 8,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NPINS-1:0] mode_o,
  output logic [NPINS-1:0] ren_o,
  output logic [NPINS-1:0] fen_o,
  output logic [NPINS-1:0] clr_o
);
  import pin_irq_pkg::*;

  logic [NPINS-1:0] wd;
  logic             w_mode, w_ren, w_rset, w_rclr, w_fen, w_fset, w_fclr, w_stat;
  logic [NPINS-1:0] mode_q, ren_q, fen_q;
  logic [NPINS-1:0] ren_d, fen_d;
  logic             ren_en, fen_en;

  assign wd     = wdata_i[NPINS-1:0];
  assign w_mode = wr_i && (addr_i == AW'(OFF_MODE));
  assign w_ren  = wr_i && (addr_i == AW'(OFF_REN));
  assign w_rset = wr_i && (addr_i == AW'(OFF_RSET));
  assign w_rclr = wr_i && (addr_i == AW'(OFF_RCLR));
  assign w_fen  = wr_i && (addr_i == AW'(OFF_FEN));
  assign w_fset = wr_i && (addr_i == AW'(OFF_FSET));
  assign w_fclr = wr_i && (addr_i == AW'(OFF_FCLR));
  assign w_stat = wr_i && (addr_i == AW'(OFF_STAT));

  always_comb begin
    ren_en = w_ren | w_rset | w_rclr;
    if (w_ren)       ren_d = wd;
    else if (w_rset) ren_d = ren_q | wd;
    else             ren_d = ren_q & ~wd;

    fen_en = w_fen | w_fset | w_fclr | w_stat;
    if (w_fen)       fen_d = wd;
    else if (w_fset) fen_d = fen_q | wd;
    else if (w_fclr) fen_d = fen_q & ~wd;
    else             fen_d = fen_q ^ (wd & mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else begin
      if (w_mode) mode_q <= wd;
      if (ren_en) ren_q  <= ren_d;
      if (fen_en) fen_q  <= fen_d;
    end
  end

  assign mode_o = mode_q;
  assign ren_o  = ren_q;
  assign fen_o  = fen_q;
  assign clr_o  = w_stat ? wd : '0;

  p_direct_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_ren |=> (ren_q == $past(wd)));
  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_rset |=> (((ren_q & $past(wd)) == $past(wd)) &&
                ((ren_q & ~$past(wd)) == ($past(ren_q) & ~$past(wd)))));
  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_rclr |=> (((ren_q & $past(wd)) == '0) &&
                ((ren_q & ~$past(wd)) == ($past(ren_q) & ~$past(wd)))));
  p_fclr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_fclr |=> ((fen_q & $past(wd)) == '0));
  p_level_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    w_stat |=> (fen_q == ($past(fen_q) ^ ($past(wd) & $past(mode_q)))));
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] ren_i,
  input  logic [NPINS-1:0] fen_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] fall_i,
  output logic [NPINS-1:0] stat_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic lat_q, lat_d, lat_en, hit, lvl_hit;

    always_comb begin
      hit     = (rise_i[i] & ren_i[i]) | (fall_i[i] & fen_i[i]);
      lat_d   = mode_i[i] ? 1'b0 : ((lat_q & ~clr_i[i]) | hit);
      lat_en  = mode_i[i] | hit | clr_i[i];
      lvl_hit = ren_i[i] & ~(lvl_i[i] ^ fen_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= 1'b0;
      else if (lat_en) lat_q <= lat_d;
    end

    assign stat_o[i] = mode_i[i] ? lvl_hit : lat_q;

    p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[i] && rise_i[i] && ren_i[i]) |=> lat_q);
    p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[i] && lat_q && !clr_i[i]) |=> lat_q);
    p_new_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[i] && clr_i[i] && ((rise_i[i] && ren_i[i]) || (fall_i[i] && fen_i[i])))
      |=> lat_q);
    p_level_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[i] && !ren_i[i]) |-> !stat_o[i]);
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NPINS = 8,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NPINS-1:0] irq_o
);
  import pin_irq_pkg::*;

  logic [NPINS-1:0] mode, ren, fen, clr, lvl, rise, fall, stat;

  pin_irq_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pin_irq_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .mode_o(mode), .ren_o(ren), .fen_o(fen), .clr_o(clr)
  );

  pin_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ren_i(ren), .fen_i(fen),
    .clr_i(clr), .lvl_i(lvl), .rise_i(rise), .fall_i(fall), .stat_o(stat)
  );

  always_comb begin
    rdata_o = '0;
    if      (addr_i == AW'(OFF_MODE)) rdata_o = DW'(mode);
    else if (addr_i == AW'(OFF_REN) || addr_i == AW'(OFF_RSET) ||
             addr_i == AW'(OFF_RCLR)) rdata_o = DW'(ren);
    else if (addr_i == AW'(OFF_FEN) || addr_i == AW'(OFF_FSET) ||
             addr_i == AW'(OFF_FCLR)) rdata_o = DW'(fen);
    else if (addr_i == AW'(OFF_STAT)) rdata_o = DW'(stat);
  end

  assign irq_o = stat;
endmodule

// File: tb/tb_pin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pin_irq_ctrl;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] pins;
  logic [4:0] addr;
  logic wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [N-1:0] irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pin_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_s3, m_mode, m_ren, m_fen, m_lat;
  logic [N-1:0] wd, clr;
  assign wd  = wdata[N-1:0];
  assign clr = (wr && addr == 5'h1C) ? wd : '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
      m_mode <= '0; m_ren <= '0; m_fen <= '0; m_lat <= '0;
    end else begin
      m_s1 <= pins; m_s2 <= m_s1; m_s3 <= m_s2;
      m_lat <= ~m_mode & ((m_lat & ~clr) | (m_s2 & ~m_s3 & m_ren) | (~m_s2 & m_s3 & m_fen));
      if (wr) begin
        case (addr)
          5'h00: m_mode <= wd;
          5'h04: m_ren <= wd;
          5'h08: m_ren <= m_ren | wd;
          5'h0C: m_ren <= m_ren & ~wd;
          5'h10: m_fen <= wd;
          5'h14: m_fen <= m_fen | wd;
          5'h18: m_fen <= m_fen & ~wd;
          5'h1C: m_fen <= m_fen ^ (wd & m_mode);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [N-1:0] exp_irq();
    return (m_mode & m_ren & ~(m_s2 ^ m_fen)) | (~m_mode & m_lat);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return 32'(m_mode);
      5'h04, 5'h08, 5'h0C: return 32'(m_ren);
      5'h10, 5'h14, 5'h18: return 32'(m_fen);
      5'h1C: return 32'(exp_irq());
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1771));
    rst_n = 1'b0; pins = '0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rreg(5'(a * 4), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);
    wreg(5'h00, 32'hA5); rreg(5'h00, v); chk("R1 mode load", v, 32'hA5);
    wreg(5'h00, 32'h00);

    // R2 / R3 rising enable views
    wreg(5'h04, 32'h3C); rreg(5'h04, v); chk("R2 direct load", v, 32'h3C);
    wreg(5'h08, 32'h81); rreg(5'h04, v); chk("R3 set alias", v, 32'hBD);
    rreg(5'h08, v); chk("R3 set alias readback", v, 32'hBD);
    wreg(5'h0C, 32'h0C); rreg(5'h0C, v); chk("R3 clear alias", v, 32'hB1);
    wreg(5'h08, 32'h00); rreg(5'h04, v); chk("R3 set zero no effect", v, 32'hB1);
    wreg(5'h0C, 32'h00); rreg(5'h04, v); chk("R3 clear zero no effect", v, 32'hB1);

    // R4 falling enable views
    wreg(5'h10, 32'h0F); wreg(5'h14, 32'h30); rreg(5'h14, v); chk("R4 set alias", v, 32'h3F);
    wreg(5'h18, 32'h05); rreg(5'h10, v); chk("R4 clear alias", v, 32'h3A);

    // R5 rising edge latency on pin 0
    wreg(5'h04, 32'h01); wreg(5'h10, 32'h00);
    pins[0] = 1'b1;
    cyc(2); chk("R5 not yet latched", 32'(irq[0]), 32'h0);
    cyc(1); chk("R5 rise latched", 32'(irq[0]), 32'h1);
    rreg(5'h1C, v); chk("R5 status read", v, 32'h01);

    // R7 status clear
    wreg(5'h1C, 32'h00); chk("R7 zero write keeps", 32'(irq[0]), 32'h1);
    wreg(5'h1C, 32'h01); chk("R7 clear", 32'(irq[0]), 32'h0);

    // R6 disabled falling edge not latched
    pins[0] = 1'b0; cyc(4); chk("R6 disabled fall", 32'(irq[0]), 32'h0);
    wreg(5'h14, 32'h01); chk("R6 late enable", 32'(irq[0]), 32'h0);

    // R5 falling edge on pin 1
    wreg(5'h14, 32'h02);
    pins[1] = 1'b1; cyc(4); chk("R6 rise on pin1 disabled", 32'(irq[1]), 32'h0);
    pins[1] = 1'b0; cyc(4); chk("R5 fall latched", 32'(irq[1]), 32'h1);
    wreg(5'h1C, 32'h02); chk("R7 clear pin1", 32'(irq[1]), 32'h0);

    // R8 clear meets new edge in the same cycle
    wreg(5'h18, 32'h01);
    pins[0] = 1'b1; cyc(2);
    addr = 5'h1C; wdata = 32'h01; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R8 new edge wins", 32'(irq[0]), 32'h1);
    wreg(5'h1C, 32'h01); chk("R8 later clear", 32'(irq[0]), 32'h0);

    // R9 / R10 level mode on pin 2 (polarity bit 2 is 0: low active)
    wreg(5'h08, 32'h04); wreg(5'h00, 32'h04);
    chk("R9 low level active", 32'(irq[2]), 32'h1);
    pins[2] = 1'b1;
    cyc(1); chk("R9 still high before sync", 32'(irq[2]), 32'h1);
    cyc(1); chk("R9 follows pin", 32'(irq[2]), 32'h0);
    wreg(5'h1C, 32'h04); rreg(5'h10, v); chk("R10 polarity flipped", v, 32'h06);
    chk("R10 high level fires", 32'(irq[2]), 32'h1);
    wreg(5'h1C, 32'h00); rreg(5'h10, v); chk("R10 zero keeps", v, 32'h06);
    wreg(5'h1C, 32'h04); rreg(5'h10, v); chk("R10 flip back", v, 32'h02);
    chk("R10 low level idle", 32'(irq[2]), 32'h0);
    wreg(5'h14, 32'h04); wreg(5'h0C, 32'h04);
    chk("R9 enable gates", 32'(irq[2]), 32'h0);
    wreg(5'h08, 32'h04); rreg(5'h1C, v); chk("R9 status level", v & 32'h4, 32'h4);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      wr = ($urandom % 3) == 0;
      addr = 5'(($urandom % 8) * 4);
      wdata = $urandom;
      if (($urandom % 4) == 0) pins = N'($urandom);
      #0.5;
      chk("R5 R9 random irq", 32'(irq), 32'(exp_irq()));
      chk("R4 R10 random read", rdata, exp_rd(addr));
    end
    @(negedge clk); wr = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule